// File: doc/BRIEF.md
# Memory Protection Rule Checker

This block judges every memory transaction that arrives at a multi-port memory front end and returns an allow or reject verdict one clock later. It holds a programmable table of protection rules. A rule can restrict a transaction by ingress port (a bitmask), by transaction ID range, by inclusive address range (1 MB units) and by security state, all at the same time. Each ingress port also has its own default verdict. Rules of the opposite polarity are the only way to overturn that default.

Exclusive accesses are handled in a different way. The rules check an exclusive read. When that read is granted, the block records a reservation for the requester. The matching exclusive write then passes on that reservation alone and does not consult the rules again. A configuration port lets firmware write rule entries and port defaults one at a time.

A typical setup puts every port at default-reject and adds two grant rules. The first covers addresses 0 to 576 for secure traffic. The second covers 512 to 2047 for non-secure traffic. Addresses 512 to 576 are then shared by both security states.

Top module: `mpc_checker`

## Requirements
- R1: For every cycle with `txn_valid` high, `resp_valid` is high exactly one clock later, carrying `resp_allow`. With no transaction, `resp_valid` is low the next cycle and `resp_allow` is low.
- R2: Reset clears every rule's valid bit and sets every port default to reject (0). A transaction that matches no valid rule receives its port's default verdict (1 = allow, 0 = reject).
- R3: On a default-reject port, a transaction is allowed only when at least one valid matching rule has its grant bit set to 1. Matching rules with grant 0 have no effect there.
- R4: On a default-allow port, a transaction is rejected only when at least one valid matching rule has its grant bit set to 0. Matching rules with grant 1 have no effect there.
- R5: A rule matches on port only when bit `txn_port` of its 10-bit port mask is 1.
- R6: A rule matches on ID only when id_lo <= `txn_id` <= id_hi, inclusive at both ends.
- R7: A rule matches on address only when addr_lo <= `txn_addr` <= addr_hi, inclusive at both ends.
- R8: The 2-bit protection selector is interpreted as follows. Value 00 matches only `txn_prot`=0. Value 01 matches only `txn_prot`=1. Values 10 and 11 match either.
- R9: A rule whose valid bit is 0 never matches. A transaction with `txn_port` >= 10 is always rejected.
- R10: An exclusive read (`txn_excl`=1, `txn_write`=0) is judged by the rules. If it is allowed, it records a reservation of its ID for its port, replacing any earlier one. If it is rejected, it clears that port's reservation.
- R11: An exclusive write is allowed exactly when its port holds a reservation with the same ID, whatever the rules say. An allowed exclusive write clears the reservation. A rejected one leaves it in place.
- R12: A configuration write in the same cycle as a transaction takes effect only from the next cycle. The transaction is judged against the earlier table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rule_we | input | 1 | Write one rule entry |
| cfg_rule_idx | input | 3 | Rule entry index |
| cfg_rule_valid | input | 1 | Rule valid bit |
| cfg_port_mask | input | 10 | Ports the rule applies to |
| cfg_id_lo | input | 12 | Lowest matching transaction ID |
| cfg_id_hi | input | 12 | Highest matching transaction ID |
| cfg_addr_lo | input | 12 | Lowest matching address (1 MB units) |
| cfg_addr_hi | input | 12 | Highest matching address (1 MB units) |
| cfg_prot_sel | input | 2 | Protection selector: 00 non-secure, 01 secure, 1x either |
| cfg_grant | input | 1 | 1 = a match allows, 0 = a match rejects |
| cfg_def_we | input | 1 | Write one port default |
| cfg_def_port | input | 4 | Port whose default is written |
| cfg_def_allow | input | 1 | New default verdict |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_port | input | 4 | Ingress port number |
| txn_id | input | 12 | Transaction ID |
| txn_addr | input | 12 | Address in 1 MB units |
| txn_prot | input | 1 | Protection (secure) bit |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_excl | input | 1 | Exclusive access |
| resp_valid | output | 1 | Verdict present |
| resp_allow | output | 1 | 1 = allowed, 0 = rejected |

## Verification
Two functions can collide in one cycle: a configuration write and the judgement of a transaction that the write would affect. The bench provokes this collision. In the same cycle, it programs a grant rule covering an address on a default-reject port and presents a transaction to that address. It expects a reject. It then repeats the transaction and expects an allow. The bench also places an exclusive read and an exclusive write back to back on one port, so that a reservation is set and then consumed in successive cycles.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    parameter int NUM_PORTS = 10;
    parameter int PORT_W    = 4;
    parameter int ID_W      = 12;
    parameter int ADDR_W    = 12;

    typedef enum logic [1:0] {
        PROT_NONSEC = 2'b00,
        PROT_SEC    = 2'b01,
        PROT_ANY_A  = 2'b10,
        PROT_ANY_B  = 2'b11
    } prot_sel_e;

    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] port_mask;
        logic [ID_W-1:0]      id_lo;
        logic [ID_W-1:0]      id_hi;
        logic [ADDR_W-1:0]    addr_lo;
        logic [ADDR_W-1:0]    addr_hi;
        prot_sel_e            prot_sel;
        logic                 grant;
    } rule_t;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic              prot;
        logic              write;
        logic              excl;
    } txn_t;

    function automatic logic port_in_range(logic [PORT_W-1:0] p);
        return int'(p) < NUM_PORTS;
    endfunction

    function automatic logic prot_matches(prot_sel_e s, logic p);
        case (s)
            PROT_NONSEC: return !p;
            PROT_SEC:    return p;
            default:     return 1'b1;
        endcase
    endfunction

    function automatic logic rule_hit(rule_t r, txn_t t);
        logic port_ok;
        port_ok = port_in_range(t.port) && r.port_mask[t.port];
        return r.valid && port_ok
            && (t.id >= r.id_lo) && (t.id <= r.id_hi)
            && (t.addr >= r.addr_lo) && (t.addr <= r.addr_hi)
            && prot_matches(r.prot_sel, t.prot);
    endfunction
endpackage

// File: rtl/mpc_rule_store.sv
module mpc_rule_store
    import mpc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    localparam int IDX_W = $clog2(NUM_RULES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            idx,
    input  rule_t                       wdata,
    output rule_t [NUM_RULES-1:0]       rules
);
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                rules[g] <= '0;
            end else if (we && int'(idx) == g) begin
                rules[g] <= wdata;
            end
        end
    end

    // R12: a written entry shows the new contents only on the next cycle
    a_r12_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> rules[$past(idx)] == $past(wdata));
endmodule

// File: rtl/mpc_rule_match.sv
module mpc_rule_match
    import mpc_pkg::*;
#(
    parameter int NUM_RULES = 8
) (
    input  rule_t [NUM_RULES-1:0] rules,
    input  txn_t                  txn,
    output logic [NUM_RULES-1:0]  grant_hits,
    output logic [NUM_RULES-1:0]  deny_hits
);
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
        logic hit;
        assign hit           = rule_hit(rules[g], txn);
        assign grant_hits[g] = hit && rules[g].grant;
        assign deny_hits[g]  = hit && !rules[g].grant;
    end

    // R9: an entry with its valid bit clear contributes no hit
    always_comb begin
        for (int i = 0; i < NUM_RULES; i++) begin
            a_r9_invalid_silent: assert (rules[i].valid || !(grant_hits[i] || deny_hits[i]));
        end
    end
endmodule

// File: rtl/mpc_excl_track.sv
module mpc_excl_track
    import mpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port,
    input  logic [ID_W-1:0]   id,
    input  logic              rd_set,
    input  logic              rd_clear,
    input  logic              wr_consume,
    output logic              held
);
    logic [NUM_PORTS-1:0] ent_valid;
    logic [ID_W-1:0]      ent_id [NUM_PORTS];

    assign held = port_in_range(port) && ent_valid[port] && (ent_id[port] == id);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_slot
        logic sel;
        assign sel = (int'(port) == g);
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
                ent_id[g]    <= '0;
            end else if (sel && rd_set) begin
                ent_valid[g] <= 1'b1;
                ent_id[g]    <= id;
            end else if (sel && (rd_clear || wr_consume)) begin
                ent_valid[g] <= 1'b0;
            end
        end
    end

    // R10: a granted exclusive read leaves a reservation for its ID
    a_r10_reserve: assert property (@(posedge clk) disable iff (rst)
        rd_set |=> ent_valid[$past(port)] && ent_id[$past(port)] == $past(id));
    // R11: a consumed reservation is gone on the next cycle
    a_r11_consume: assert property (@(posedge clk) disable iff (rst)
        wr_consume |=> !ent_valid[$past(port)]);
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
    import mpc_pkg::*;
#(
    parameter int NUM_RULES = 8,
    localparam int IDX_W = $clog2(NUM_RULES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_rule_we,
    input  logic [IDX_W-1:0]     cfg_rule_idx,
    input  logic                 cfg_rule_valid,
    input  logic [NUM_PORTS-1:0] cfg_port_mask,
    input  logic [ID_W-1:0]      cfg_id_lo,
    input  logic [ID_W-1:0]      cfg_id_hi,
    input  logic [ADDR_W-1:0]    cfg_addr_lo,
    input  logic [ADDR_W-1:0]    cfg_addr_hi,
    input  logic [1:0]           cfg_prot_sel,
    input  logic                 cfg_grant,
    input  logic                 cfg_def_we,
    input  logic [PORT_W-1:0]    cfg_def_port,
    input  logic                 cfg_def_allow,
    input  logic                 txn_valid,
    input  logic [PORT_W-1:0]    txn_port,
    input  logic [ID_W-1:0]      txn_id,
    input  logic [ADDR_W-1:0]    txn_addr,
    input  logic                 txn_prot,
    input  logic                 txn_write,
    input  logic                 txn_excl,
    output logic                 resp_valid,
    output logic                 resp_allow
);
    rule_t                 wrule;
    txn_t                  txn;
    rule_t [NUM_RULES-1:0] rules;
    logic [NUM_RULES-1:0]  grant_hits, deny_hits;
    logic [NUM_PORTS-1:0]  def_allow;
    logic port_ok, dflt, rule_verdict, excl_wr, excl_rd, held, verdict;

    assign wrule = '{valid: cfg_rule_valid, port_mask: cfg_port_mask,
                     id_lo: cfg_id_lo, id_hi: cfg_id_hi,
                     addr_lo: cfg_addr_lo, addr_hi: cfg_addr_hi,
                     prot_sel: prot_sel_e'(cfg_prot_sel), grant: cfg_grant};
    assign txn   = '{port: txn_port, id: txn_id, addr: txn_addr,
                     prot: txn_prot, write: txn_write, excl: txn_excl};

    mpc_rule_store #(.NUM_RULES(NUM_RULES)) u_store (
        .clk(clk), .rst(rst), .we(cfg_rule_we), .idx(cfg_rule_idx),
        .wdata(wrule), .rules(rules)
    );

    mpc_rule_match #(.NUM_RULES(NUM_RULES)) u_match (
        .rules(rules), .txn(txn), .grant_hits(grant_hits), .deny_hits(deny_hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            def_allow <= '0;
        end else if (cfg_def_we && port_in_range(cfg_def_port)) begin
            def_allow[cfg_def_port] <= cfg_def_allow;
        end
    end

    assign port_ok      = port_in_range(txn_port);
    assign dflt         = port_ok && def_allow[txn_port];
    assign rule_verdict = dflt ? !(|deny_hits) : (|grant_hits);
    assign excl_wr      = txn_valid && port_ok && txn_excl && txn_write;
    assign excl_rd      = txn_valid && port_ok && txn_excl && !txn_write;
    assign verdict      = !port_ok ? 1'b0 : (txn_excl && txn_write) ? held : rule_verdict;

    mpc_excl_track u_excl (
        .clk(clk), .rst(rst), .port(txn_port), .id(txn_id),
        .rd_set(excl_rd && rule_verdict), .rd_clear(excl_rd && !rule_verdict),
        .wr_consume(excl_wr && held), .held(held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= txn_valid;
            resp_allow <= txn_valid && verdict;
        end
    end

    // R1: one verdict per transaction, one cycle later
    a_r1_resp_timing: assert property (@(posedge clk) disable iff (rst)
        resp_valid == $past(txn_valid));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> !resp_allow);
    // R9: ports beyond the implemented count are always rejected
    a_r9_bad_port: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !port_ok |=> resp_valid && !resp_allow);
    // R11: exclusive write without a reservation is rejected
    a_r11_no_resv_reject: assert property (@(posedge clk) disable iff (rst)
        excl_wr && !held |=> !resp_allow);
    // R2: with no matching rule the port default decides
    a_r2_default_rules: assert property (@(posedge clk) disable iff (rst)
        txn_valid && port_ok && !(txn_excl && txn_write) && grant_hits == '0 && deny_hits == '0
        |=> resp_allow == $past(dflt));
endmodule

// File: tb/mpc_checker_bench.sv
module mpc_checker_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_rule_we = 0;
    logic [2:0]  cfg_rule_idx = 0;
    logic        cfg_rule_valid = 0;
    logic [9:0]  cfg_port_mask = 0;
    logic [11:0] cfg_id_lo = 0, cfg_id_hi = 0, cfg_addr_lo = 0, cfg_addr_hi = 0;
    logic [1:0]  cfg_prot_sel = 0;
    logic        cfg_grant = 0;
    logic        cfg_def_we = 0;
    logic [3:0]  cfg_def_port = 0;
    logic        cfg_def_allow = 0;
    logic        txn_valid = 0;
    logic [3:0]  txn_port = 0;
    logic [11:0] txn_id = 0, txn_addr = 0;
    logic        txn_prot = 0, txn_write = 0, txn_excl = 0;
    logic        resp_valid, resp_allow;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mpc_checker u_mpc_checker (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_rule(input int idx, input logic v, input logic [9:0] mask,
                            input int idlo, input int idhi, input int alo, input int ahi,
                            input logic [1:0] ps, input logic g);
        @(negedge clk);
        cfg_rule_we = 1; cfg_rule_idx = 3'(idx); cfg_rule_valid = v; cfg_port_mask = mask;
        cfg_id_lo = 12'(idlo); cfg_id_hi = 12'(idhi); cfg_addr_lo = 12'(alo); cfg_addr_hi = 12'(ahi);
        cfg_prot_sel = ps; cfg_grant = g;
        @(negedge clk);
        cfg_rule_we = 0;
    endtask

    task automatic set_def(input int p, input logic a);
        @(negedge clk);
        cfg_def_we = 1; cfg_def_port = 4'(p); cfg_def_allow = a;
        @(negedge clk);
        cfg_def_we = 0;
    endtask

    // Drive at a falling edge, the verdict registers at the next rising edge.
    task automatic probe(input int p, input int id, input int addr, input logic prot,
                         input logic wr, input logic ex, input logic exp, input string req);
        @(negedge clk);
        txn_valid = 1; txn_port = 4'(p); txn_id = 12'(id); txn_addr = 12'(addr);
        txn_prot = prot; txn_write = wr; txn_excl = ex;
        @(posedge clk); #1;
        txn_valid = 0;
        check(resp_valid === 1'b1, req, int'(resp_valid), 1);
        check(resp_allow === exp, req, int'(resp_allow), int'(exp));
    endtask

    task automatic t_reset;
        check(resp_valid === 1'b0 && resp_allow === 1'b0, "R2", int'(resp_valid), 0);
        probe(0, 0, 0, 1, 0, 0, 0, "R2");           // reset default reject, no rules
        @(posedge clk); #1;
        check(resp_valid === 1'b0 && resp_allow === 1'b0, "R1", int'(resp_valid), 0);
    endtask

    task automatic t_defaults;
        set_def(2, 1);
        probe(2, 7, 900, 0, 1, 0, 1, "R2");
        set_def(2, 0);
        probe(2, 7, 900, 0, 1, 0, 0, "R2");
    endtask

    task automatic t_two_zone;
        set_rule(0, 1, 10'h3FF, 0, 4095, 0, 576, 2'b01, 1);
        set_rule(1, 1, 10'h3FF, 0, 4095, 512, 2047, 2'b00, 1);
        probe(0, 1, 0, 1, 0, 0, 1, "R7");
        probe(1, 2, 576, 1, 0, 0, 1, "R7");
        probe(1, 2, 577, 1, 0, 0, 0, "R7");
        probe(3, 2, 512, 0, 1, 0, 1, "R7");
        probe(3, 2, 511, 0, 0, 0, 0, "R8");
        probe(4, 9, 2047, 0, 0, 0, 1, "R7");
        probe(4, 9, 540, 1, 0, 0, 1, "R8");
        probe(4, 9, 540, 0, 0, 0, 1, "R8");
        probe(4, 9, 2048, 0, 0, 0, 0, "R3");
    endtask

    task automatic t_prot_any;
        set_rule(2, 1, 10'h3FF, 0, 4095, 3000, 3000, 2'b10, 1);
        probe(0, 0, 3000, 0, 0, 0, 1, "R8");
        probe(0, 0, 3000, 1, 0, 0, 1, "R8");
        set_rule(2, 1, 10'h3FF, 0, 4095, 3000, 3000, 2'b11, 1);
        probe(0, 0, 3000, 1, 0, 0, 1, "R8");
    endtask

    task automatic t_mask;
        set_rule(3, 1, 10'b0000100000, 0, 4095, 3100, 3100, 2'b10, 1);
        probe(5, 0, 3100, 0, 0, 0, 1, "R5");
        probe(4, 0, 3100, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_id;
        set_rule(4, 1, 10'h3FF, 100, 200, 3200, 3200, 2'b10, 1);
        probe(0, 100, 3200, 0, 0, 0, 1, "R6");
        probe(0, 200, 3200, 0, 0, 0, 1, "R6");
        probe(0, 99, 3200, 0, 0, 0, 0, "R6");
        probe(0, 201, 3200, 0, 0, 0, 0, "R6");
    endtask

    task automatic t_deny_rules;
        set_def(7, 1);
        set_rule(5, 1, 10'h3FF, 0, 4095, 3300, 3310, 2'b10, 0);
        probe(7, 0, 3305, 0, 0, 0, 0, "R4");
        probe(7, 0, 3311, 0, 0, 0, 1, "R4");
        probe(7, 0, 100, 1, 0, 0, 1, "R4");         // grant rule on allow port: no change
        probe(6, 0, 3305, 0, 0, 0, 0, "R3");        // deny rule on reject port: no change
    endtask

    task automatic t_invalid;
        set_rule(6, 0, 10'h3FF, 0, 4095, 3400, 3400, 2'b10, 1);
        probe(1, 0, 3400, 0, 0, 0, 0, "R9");
        probe(12, 0, 0, 1, 0, 0, 0, "R9");
        probe(10, 0, 540, 0, 0, 0, 0, "R9");
    endtask

    task automatic t_excl;
        probe(1, 5, 10, 1, 1, 1, 0, "R11");         // no reservation
        probe(1, 5, 10, 1, 0, 1, 1, "R10");         // reserve id 5
        probe(1, 6, 10, 1, 1, 1, 0, "R11");         // other id
        probe(1, 5, 10, 1, 1, 1, 1, "R11");         // consume
        probe(1, 5, 10, 1, 1, 1, 0, "R11");         // already cleared
        probe(1, 5, 10, 1, 0, 1, 1, "R10");
        probe(1, 5, 4000, 0, 0, 1, 0, "R10");       // rejected read clears
        probe(1, 5, 10, 1, 1, 1, 0, "R10");
        probe(1, 5, 10, 1, 0, 1, 1, "R10");
        probe(1, 5, 4000, 0, 1, 1, 1, "R11");       // rules bypassed for the write
        probe(1, 8, 10, 1, 0, 1, 1, "R10");         // new read replaces id
        probe(1, 5, 10, 1, 1, 1, 0, "R10");
        probe(1, 8, 10, 1, 1, 1, 1, "R10");
        probe(1, 0, 4000, 0, 1, 0, 0, "R3");        // plain write still ruled
    endtask

    task automatic t_collide;
        @(negedge clk);
        cfg_rule_we = 1; cfg_rule_idx = 3'd7; cfg_rule_valid = 1; cfg_port_mask = 10'b0000001000;
        cfg_id_lo = 0; cfg_id_hi = 12'd4095; cfg_addr_lo = 12'd3500; cfg_addr_hi = 12'd3500;
        cfg_prot_sel = 2'b10; cfg_grant = 1;
        txn_valid = 1; txn_port = 4'd3; txn_id = 0; txn_addr = 12'd3500;
        txn_prot = 0; txn_write = 0; txn_excl = 0;
        @(posedge clk); #1;
        cfg_rule_we = 0; txn_valid = 0;
        check(resp_valid === 1'b1 && resp_allow === 1'b0, "R12", int'(resp_allow), 0);
        probe(3, 0, 3500, 0, 0, 0, 1, "R12");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(resp_valid === 1'b0, "R1", int'(resp_valid), 0);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_defaults();
        t_two_zone();
        t_prot_any();
        t_mask();
        t_id();
        t_deny_rules();
        t_invalid();
        t_excl();
        t_collide();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule